// File: doc/BRIEF.md
# Two-Source Vectored Interrupt Controller

This block sits beside a small 8-bit processor core. It arbitrates between two interrupt sources, an external pin event and a timer overflow event. One control word holds the controller's state: a master enable, a per-source enable and a per-source pending flag. Software writes the whole word and can read it back at any time.

A source event always latches its pending flag. The flag stays set until that source is serviced or until software overwrites it.

The core raises a one-cycle instruction-boundary strobe. In that cycle the controller takes an interrupt only if all of these hold:
- the master enable is set;
- some enabled source is pending;
- the core's return-address stack is not full.

When it takes an interrupt, the controller does three things:
- It pulses an acknowledge to the core in the next cycle, with the entry address of the winning source.
- It clears the master enable, which blocks nesting while new requests keep latching.
- It clears the winner's pending flag.

A return-from-interrupt strobe from the core sets the master enable again. The service routine may also set the master enable itself to allow nesting.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Control word layout is bit 0 master enable, bit 1 external enable, bit 2 timer enable, bit 3 external pending, bit 4 timer pending, and bits 7:5 always read zero. A write stores the word, and it reads back on `ctl_q` in the following cycle, so writing 0x05 sets the master and timer enables.
- R2: An event on a source sets its pending flag one cycle later, whatever the state of the enables.
- R3: No acknowledge is issued while the master enable is 0.
- R4: A pending source whose own enable bit is 0 is never acknowledged.
- R5: When `boundary` is high, the master enable is 1, `stack_full` is 0 and an enabled source is pending, `ack` is high for exactly the next cycle. No acknowledge occurs without `boundary`.
- R6: `ack_vec` is 0x04 for the external source and 0x08 for the timer. When both are eligible, the external source wins.
- R7: The acknowledge clears the master enable and the winner's pending flag, visible in the acknowledge cycle. The other flag is unchanged.
- R8: While `stack_full` is high, no acknowledge is issued. A pending request is acknowledged at the first boundary after `stack_full` falls.
- R9: A `reti` strobe sets the master enable in the next cycle, unless an acknowledge is taken in the same cycle.
- R10: An event that coincides with the clearing of its own flag by an acknowledge leaves the flag set.
- R11: Setting the master enable inside a service routine lets a further pending source be acknowledged (nesting).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word write value |
| ctl_q | output | 8 | Control word read value |
| ext_evt | input | 1 | External source event |
| tmr_evt | input | 1 | Timer overflow event |
| boundary | input | 1 | Instruction boundary strobe from the core |
| stack_full | input | 1 | Return-address stack is full |
| reti | input | 1 | Return-from-interrupt strobe |
| ack | output | 1 | Interrupt acknowledge pulse |
| ack_vec | output | 8 | Entry address for the acknowledged source |

## Verification
The whole state of this controller is visible on `ctl_q`. A wrong flag or enable bit therefore shows at the ports one cycle after the write, event or acknowledge that caused it.

Wrong gating or arbitration shows in the cycle right after the boundary, in one of three ways:
- `ack` is missing or spurious;
- `ack_vec` carries the wrong address;
- a flag that should have been cleared is still set, or the reverse.

The bench sweeps every combination of the 5-bit control word against both stack states. It then drives directed sequences for the event, return, nesting and coincident-clear cases.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;

  // bit position of the master enable
  function automatic int gie_pos();
    return 0;
  endfunction

  // bit position of enable for source idx
  function automatic int en_pos(int idx);
    return 1 + idx;
  endfunction

  // bit position of pending flag for source idx among nsrc sources
  function automatic int fl_pos(int idx, int nsrc);
    return 1 + nsrc + idx;
  endfunction

  // entry address of source idx
  function automatic logic [7:0] vec_of(int idx, int base, int step);
    return 8'(base + step * idx);
  endfunction

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC     = 2,
  parameter int VW       = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input  logic [NSRC-1:0] req_en,
  input  logic            gie,
  input  logic            boundary,
  input  logic            stack_full,
  output logic            take,
  output logic [NSRC-1:0] win_oh,
  output logic [VW-1:0]   win_vec
);
  import vec_irq_pkg::*;

  logic [NSRC:0] seen;

  // lower index has priority; seen[i] marks a higher-priority request
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NSRC; i++) begin : g_pri
    assign win_oh[i]  = req_en[i] & ~seen[i];
    assign seen[i+1]  = seen[i] | req_en[i];
  end

  always_comb begin
    win_vec = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (win_oh[i]) win_vec = VW'(vec_of(i, VEC_BASE, VEC_STEP));
    end
  end

  assign take = boundary & gie & ~stack_full & seen[NSRC];
endmodule

// File: rtl/irq_ctlreg.sv
module irq_ctlreg #(
  parameter int NSRC = 2,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  input  logic [NSRC-1:0] evt,
  input  logic            take,
  input  logic [NSRC-1:0] win_oh,
  input  logic            reti,
  output logic [DW-1:0]   ctl_q,
  output logic            gie,
  output logic [NSRC-1:0] req_en
);
  import vec_irq_pkg::*;

  localparam int USED = 1 + 2 * NSRC;
  localparam logic [DW-1:0] MASK = DW'((1 << USED) - 1);

  logic [DW-1:0] cur_q, nxt;

  always_comb begin
    nxt = wr_en ? (wr_data & MASK) : cur_q;
    if (take) begin
      nxt[gie_pos()] = 1'b0;
      for (int i = 0; i < NSRC; i++)
        if (win_oh[i]) nxt[fl_pos(i, NSRC)] = 1'b0;
    end else if (reti) begin
      nxt[gie_pos()] = 1'b1;
    end
    // new events win over any clear in the same cycle
    for (int i = 0; i < NSRC; i++)
      if (evt[i]) nxt[fl_pos(i, NSRC)] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= nxt;
  end

  assign ctl_q = cur_q;
  assign gie   = cur_q[gie_pos()];

  for (genvar i = 0; i < NSRC; i++) begin : g_req
    assign req_en[i] = cur_q[en_pos(i)] & cur_q[fl_pos(i, NSRC)];
  end
endmodule

// File: rtl/irq_ackgen.sv
module irq_ackgen #(
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [VW-1:0] win_vec,
  output logic          ack,
  output logic [VW-1:0] ack_vec
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack     <= 1'b0;
      ack_vec <= '0;
    end else begin
      ack <= take;
      if (take) ack_vec <= win_vec;
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int NSRC     = 2,
  parameter int DW       = 8,
  parameter int VW       = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] ctl_q,
  input  logic          ext_evt,
  input  logic          tmr_evt,
  input  logic          boundary,
  input  logic          stack_full,
  input  logic          reti,
  output logic          ack,
  output logic [VW-1:0] ack_vec
);
  logic [NSRC-1:0] evt;
  logic [NSRC-1:0] req_en;
  logic [NSRC-1:0] win_oh;
  logic [VW-1:0]   win_vec;
  logic            gie;
  logic            take;

  assign evt = NSRC'({tmr_evt, ext_evt});

  irq_ctlreg #(.NSRC(NSRC), .DW(DW)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .evt(evt), .take(take), .win_oh(win_oh), .reti(reti),
    .ctl_q(ctl_q), .gie(gie), .req_en(req_en)
  );

  irq_arbiter #(.NSRC(NSRC), .VW(VW), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_arb (
    .req_en(req_en), .gie(gie), .boundary(boundary), .stack_full(stack_full),
    .take(take), .win_oh(win_oh), .win_vec(win_vec)
  );

  irq_ackgen #(.VW(VW)) u_ack (
    .clk(clk), .rst_n(rst_n), .take(take), .win_vec(win_vec),
    .ack(ack), .ack_vec(ack_vec)
  );
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int NSRC     = 2,
  parameter int DW       = 8,
  parameter int VW       = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] ctl_q,
  input logic          ext_evt,
  input logic          tmr_evt,
  input logic          boundary,
  input logic          stack_full,
  input logic          reti,
  input logic          ack,
  input logic [VW-1:0] ack_vec,
  input logic          take
);
  localparam int FL_LO = 1 + NSRC;

  logic [NSRC-1:0] evt_w;
  logic [NSRC-1:0] fl_w;
  assign evt_w = NSRC'({tmr_evt, ext_evt});
  assign fl_w  = ctl_q[FL_LO +: NSRC];

  p_ack_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  p_ack_after_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(boundary));
  p_ack_needs_gie_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(ctl_q[0]));
  p_ack_stack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !$past(stack_full));
  p_gie_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !ctl_q[0]);
  p_vec_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (ack_vec >= VW'(VEC_BASE)) && ((ack_vec - VW'(VEC_BASE)) % VW'(VEC_STEP) == 0));
  p_reti_gie_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reti) && !ack) |-> ctl_q[0]);
  p_evt_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(evt_w) & ~fl_w) == '0));
  p_take_to_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ack);
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(
  .NSRC(NSRC), .DW(DW), .VW(VW), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .ext_evt(ext_evt), .tmr_evt(tmr_evt),
  .boundary(boundary), .stack_full(stack_full), .reti(reti),
  .ack(ack), .ack_vec(ack_vec), .take(take)
);

// File: tb/vec_irq_ctrl_tb_top.sv
module vec_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] ctl_q;
  logic       ext_evt = 1'b0, tmr_evt = 1'b0;
  logic       boundary = 1'b0, stack_full = 1'b0, reti = 1'b0;
  logic       ack;
  logic [7:0] ack_vec;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vec_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ctl_q(ctl_q),
    .ext_evt(ext_evt), .tmr_evt(tmr_evt), .boundary(boundary),
    .stack_full(stack_full), .reti(reti), .ack(ack), .ack_vec(ack_vec)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] v);
    wr_en = 1'b1;
    wr_data = v;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic bnd(logic sf);
    boundary = 1'b1;
    stack_full = sf;
    tick();
    boundary = 1'b0;
    stack_full = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ctl", ctl_q, 8'h00);
    chk("R5 reset ack", {7'd0, ack}, 8'h00);
    rst_n = 1'b1;
    tick();

    // R1: reserved bits read as zero, 0x05 sets master + timer enable
    wr(8'hE5);
    chk("R1 masked write", ctl_q, 8'h05);

    // sweep all control words against both stack states
    for (int v = 0; v < 32; v++) begin
      for (int sf = 0; sf < 2; sf++) begin
        logic [1:0] pe;
        logic       go;
        int         src;
        logic [7:0] vx;
        vx = 8'(v);
        pe = vx[2:1] & vx[4:3];
        go = vx[0] && (sf == 0) && (pe != 2'b00);
        src = pe[0] ? 0 : 1;
        wr(vx);
        chk("R1 readback", ctl_q, vx);
        bnd(sf[0]);
        // R3 R4 R5 R8: acknowledge condition
        chk("R5 ack sweep", {7'd0, ack}, {7'd0, go});
        if (go) begin
          chk("R6 vector sweep", ack_vec, 8'(4 + 4 * src));
          chk("R7 clear sweep", ctl_q, vx & ~(8'h01 | (8'h08 << src)));
        end else begin
          chk("R3 R4 R8 unchanged", ctl_q, vx);
        end
        tick();
        chk("R5 single pulse", {7'd0, ack}, 8'h00);
      end
    end

    // R2 + R3: event latches while master enable is off, no acknowledge
    wr(8'h04);
    tmr_evt = 1'b1;
    tick();
    tmr_evt = 1'b0;
    chk("R2 timer latch", ctl_q, 8'h14);
    bnd(1'b0);
    chk("R3 gie off no ack", {7'd0, ack}, 8'h00);
    ext_evt = 1'b1;
    tick();
    ext_evt = 1'b0;
    chk("R2 ext latch", ctl_q, 8'h1C);

    // R5 without boundary nothing happens
    wr(8'h15);
    tick();
    tick();
    chk("R5 no boundary", {7'd0, ack}, 8'h00);

    // R9: reti sets master enable
    wr(8'h04);
    reti = 1'b1;
    tick();
    reti = 1'b0;
    chk("R9 reti gie", ctl_q, 8'h05);

    // R8: stack full withholds, release allows
    wr(8'h0B);
    for (int k = 0; k < 3; k++) begin
      bnd(1'b1);
      chk("R8 held", {7'd0, ack}, 8'h00);
    end
    chk("R8 still pending", ctl_q, 8'h0B);
    bnd(1'b0);
    chk("R8 released ack", {7'd0, ack}, 8'h01);
    chk("R8 released vec", ack_vec, 8'h04);
    chk("R8 released ctl", ctl_q, 8'h02);

    // R10: event coincident with its own clear keeps the flag
    wr(8'h15);
    boundary = 1'b1;
    tmr_evt = 1'b1;
    tick();
    boundary = 1'b0;
    tmr_evt = 1'b0;
    chk("R10 ack", {7'd0, ack}, 8'h01);
    chk("R10 flag kept", ctl_q, 8'h14);

    // R11: nesting by setting master enable inside service
    wr(8'h1F);
    bnd(1'b0);
    chk("R6 priority vec", ack_vec, 8'h04);
    chk("R7 other flag kept", ctl_q, 8'h16);
    bnd(1'b0);
    chk("R11 blocked before reenable", {7'd0, ack}, 8'h00);
    wr(8'h17);
    bnd(1'b0);
    chk("R11 nested ack", {7'd0, ack}, 8'h01);
    chk("R11 nested vec", ack_vec, 8'h08);
    chk("R11 nested ctl", ctl_q, 8'h06);

    // R9 with a coincident acknowledge: acknowledge wins
    wr(8'h0B);
    boundary = 1'b1;
    reti = 1'b1;
    tick();
    boundary = 1'b0;
    reti = 1'b0;
    chk("R9 ack over reti", ctl_q, 8'h02);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule